// File: doc/BRIEF.md
# Signed Split-Bank Up/Down Counter

This block counts up and down using two separate unsigned occupancy banks. The positive bank holds upward counts and the negative bank holds downward counts. The signed value the block reports is the positive occupancy minus the negative occupancy. Each bank is a thermometer register of `DEPTH` slots, so the value can range from -`DEPTH` to +`DEPTH`. Making `DEPTH` larger widens the range equally on both sides, and the control logic does not change.

On every clock edge, a Mealy control machine looks at the two single-cycle request inputs. An increment on its own first empties a slot in the negative bank. If the negative bank is already empty, it fills a slot in the positive bank instead. A decrement on its own does the mirror of this. Asserting both requests in the same cycle is a read command, not a net-zero update. A read leaves the banks untouched and returns the value on a result port, with a one-cycle valid strobe. A fill request to a bank that is already full is refused, and the matching saturation flag pulses.

The control machine has three states:
- `ST_ZERO`: both banks are empty.
- `ST_POS`: only the positive bank holds slots.
- `ST_NEG`: only the negative bank holds slots.

It has four transitions:
- `ZERO->POS` on an increment.
- `ZERO->NEG` on a decrement.
- `POS->ZERO` on a decrement that drains the last positive slot.
- `NEG->ZERO` on an increment that drains the last negative slot.

Every other case stays in the current state.

Top module: `split_bank_counter`

## Requirements
- R1: An increment alone (`up_i`=1, `down_i`=0) raises `value_o` by one on the next clock, unless the value is already +`DEPTH`.
- R2: A decrement alone lowers `value_o` by one on the next clock, unless the value is already -`DEPTH`.
- R3: At most one bank is ever occupied. An increment at a negative value, or a decrement at a positive value, moves the value toward zero, and counting crosses zero in both directions without a gap.
- R4: With both `up_i` and `down_i` high, `value_o` does not change.
- R5: One clock after a read, `rd_valid_o` is high for exactly one cycle. In that cycle `rd_value_o` holds the two's-complement value from the read cycle. `rd_valid_o` is low after any cycle that was not a read.
- R6: An increment at +`DEPTH` leaves the value at +`DEPTH`, and `ovf_o` is high for the following cycle only.
- R7: A decrement at -`DEPTH` leaves the value at -`DEPTH`, and `udf_o` is high for the following cycle only.
- R8: While `rst_n` is low, and after it is released, `value_o` is 0 and `rd_valid_o`, `ovf_o` and `udf_o` are low. This holds even when reset is applied at a non-zero value.
- R9: Each bank stays a thermometer code. Its occupied slots always form a contiguous run starting from slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_i | input | 1 | Increment request |
| down_i | input | 1 | Decrement request; together with `up_i`, a read |
| value_o | output | $clog2(DEPTH+1)+1 | Signed current value, two's complement |
| rd_valid_o | output | 1 | One-cycle strobe following a read |
| rd_value_o | output | $clog2(DEPTH+1)+1 | Value captured by the last read |
| ovf_o | output | 1 | Refused increment at the positive limit |
| udf_o | output | 1 | Refused decrement at the negative limit |

## Verification
The properties assume the request inputs are synchronous levels. Each sampled cycle is treated as one request, so a request held for several cycles counts as several requests. The properties also assume reset is applied at least once before counting begins.

The bench changes the inputs only on falling edges. Every request is one cycle long and is separated from the next by a sampling point. The bench then drives the value into both saturation limits and through zero. It also issues reads at positive, negative and zero values, and back to back.

// File: rtl/sbc_pkg.sv
package sbc_pkg;

    typedef enum logic [1:0] {
        ST_ZERO = 2'd0,
        ST_POS  = 2'd1,
        ST_NEG  = 2'd2
    } sbc_state_e;

endpackage

// File: rtl/sbc_bank.sv
module sbc_bank #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fill_i,
    input  logic          drain_i,
    output logic [CW-1:0] cnt_o,
    output logic          full_o,
    output logic          any_o,
    output logic          last_o
);

    logic [DEPTH-1:0] therm_q;
    logic [DEPTH-1:0] therm_d;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic from_below;
        logic from_above;
        if (i == 0) begin : g_bot
            assign from_below = 1'b1;
        end else begin : g_mid
            assign from_below = therm_q[i-1];
        end
        if (i == DEPTH - 1) begin : g_top
            assign from_above = 1'b0;
        end else begin : g_low
            assign from_above = therm_q[i+1];
        end
        always_comb begin
            if (fill_i)       therm_d[i] = from_below;
            else if (drain_i) therm_d[i] = from_above;
            else              therm_d[i] = therm_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) therm_q <= '0;
        else        therm_q <= therm_d;
    end

    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < DEPTH; i++) cnt_o = cnt_o + CW'(therm_q[i]);
    end

    assign full_o = therm_q[DEPTH-1];
    assign any_o  = therm_q[0];
    assign last_o = (cnt_o == CW'(1));

    AST_THERM_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        ((therm_q + DEPTH'(1)) & therm_q) == '0);  // R9
    AST_BANK_ONE_OP: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_i && drain_i));  // R3

endmodule

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
    import sbc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic up_i,
    input  logic down_i,
    input  logic pos_any_i,
    input  logic neg_any_i,
    input  logic pos_full_i,
    input  logic neg_full_i,
    input  logic pos_last_i,
    input  logic neg_last_i,
    output logic pos_fill_o,
    output logic pos_drain_o,
    output logic neg_fill_o,
    output logic neg_drain_o,
    output logic read_o,
    output logic sat_hi_o,
    output logic sat_lo_o
);

    sbc_state_e state_q, state_d;
    logic up_only, down_only;

    assign up_only   = up_i && !down_i;
    assign down_only = down_i && !up_i;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ZERO;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d     = state_q;
        pos_fill_o  = 1'b0;
        pos_drain_o = 1'b0;
        neg_fill_o  = 1'b0;
        neg_drain_o = 1'b0;
        sat_hi_o    = 1'b0;
        sat_lo_o    = 1'b0;
        read_o      = up_i && down_i;
        unique case (state_q)
            ST_ZERO: begin
                if (up_only) begin
                    pos_fill_o = 1'b1;
                    state_d    = ST_POS;
                end else if (down_only) begin
                    neg_fill_o = 1'b1;
                    state_d    = ST_NEG;
                end
            end
            ST_POS: begin
                if (up_only) begin
                    if (pos_full_i) sat_hi_o   = 1'b1;
                    else            pos_fill_o = 1'b1;
                end else if (down_only) begin
                    pos_drain_o = 1'b1;
                    if (pos_last_i) state_d = ST_ZERO;
                end
            end
            ST_NEG: begin
                if (down_only) begin
                    if (neg_full_i) sat_lo_o   = 1'b1;
                    else            neg_fill_o = 1'b1;
                end else if (up_only) begin
                    neg_drain_o = 1'b1;
                    if (neg_last_i) state_d = ST_ZERO;
                end
            end
            default: state_d = ST_ZERO;
        endcase
    end

    AST_ZERO_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ZERO) |-> (!pos_any_i && !neg_any_i));  // R3
    AST_POS_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POS) |-> (pos_any_i && !neg_any_i));  // R3
    AST_NEG_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NEG) |-> (neg_any_i && !pos_any_i));  // R3

endmodule

// File: rtl/split_bank_counter.sv
module split_bank_counter #(
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int VW   = CW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          up_i,
    input  logic          down_i,
    output logic [VW-1:0] value_o,
    output logic          rd_valid_o,
    output logic [VW-1:0] rd_value_o,
    output logic          ovf_o,
    output logic          udf_o
);

    localparam logic signed [VW-1:0] MAXV = VW'(DEPTH);
    localparam logic signed [VW-1:0] MINV = -VW'(DEPTH);

    logic [CW-1:0] pos_cnt, neg_cnt;
    logic pos_full, neg_full, pos_any, neg_any, pos_last, neg_last;
    logic pos_fill, pos_drain, neg_fill, neg_drain;
    logic is_read, sat_hi, sat_lo;
    logic signed [VW-1:0] value_s;

    sbc_bank #(.DEPTH(DEPTH)) u_pos (
        .clk(clk), .rst_n(rst_n), .fill_i(pos_fill), .drain_i(pos_drain),
        .cnt_o(pos_cnt), .full_o(pos_full), .any_o(pos_any), .last_o(pos_last)
    );

    sbc_bank #(.DEPTH(DEPTH)) u_neg (
        .clk(clk), .rst_n(rst_n), .fill_i(neg_fill), .drain_i(neg_drain),
        .cnt_o(neg_cnt), .full_o(neg_full), .any_o(neg_any), .last_o(neg_last)
    );

    sbc_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .up_i(up_i), .down_i(down_i),
        .pos_any_i(pos_any), .neg_any_i(neg_any),
        .pos_full_i(pos_full), .neg_full_i(neg_full),
        .pos_last_i(pos_last), .neg_last_i(neg_last),
        .pos_fill_o(pos_fill), .pos_drain_o(pos_drain),
        .neg_fill_o(neg_fill), .neg_drain_o(neg_drain),
        .read_o(is_read), .sat_hi_o(sat_hi), .sat_lo_o(sat_lo)
    );

    assign value_s = $signed({1'b0, pos_cnt}) - $signed({1'b0, neg_cnt});
    assign value_o = value_s;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_o <= 1'b0;
            rd_value_o <= '0;
            ovf_o      <= 1'b0;
            udf_o      <= 1'b0;
        end else begin
            rd_valid_o <= is_read;
            if (is_read) rd_value_o <= value_s;
            ovf_o <= sat_hi;
            udf_o <= sat_lo;
        end
    end

    AST_ONE_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
        !(pos_any && neg_any));  // R3
    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && !down_i && value_s != MAXV) |=> value_s == $past(value_s) + VW'(1));  // R1
    AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (down_i && !up_i && value_s != MINV) |=> value_s == $past(value_s) - VW'(1));  // R2
    AST_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && down_i) |=> $stable(value_s));  // R4
    AST_READ_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && down_i) |=> (rd_valid_o && rd_value_o == value_o));  // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> value_s == MAXV);  // R6
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        udf_o |-> value_s == MINV);  // R7

endmodule

// File: tb/tb_split_bank_counter.sv
module tb_split_bank_counter;

    localparam int DEPTH = 3;
    localparam int VW    = $clog2(DEPTH + 1) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up_i = 1'b0, down_i = 1'b0;
    logic [VW-1:0] value_o, rd_value_o;
    logic rd_valid_o, ovf_o, udf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    split_bank_counter #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .up_i(up_i), .down_i(down_i),
        .value_o(value_o), .rd_valid_o(rd_valid_o), .rd_value_o(rd_value_o),
        .ovf_o(ovf_o), .udf_o(udf_o)
    );

    // vector: {up, down, exp_rdv, exp_ovf, exp_udf, exp_value[7:0]}
    localparam int NV = 18;
    localparam logic [12:0] VEC [NV] = '{
        {5'b10000, 8'sd1},   // R1
        {5'b10000, 8'sd2},   // R1
        {5'b11100, 8'sd2},   // R4 R5 read positive
        {5'b10000, 8'sd3},   // R1
        {5'b10010, 8'sd3},   // R6 refused
        {5'b00000, 8'sd3},   // R6 flag drops
        {5'b01000, 8'sd2},   // R2 R3
        {5'b01000, 8'sd1},
        {5'b01000, 8'sd0},   // R3 reach zero
        {5'b01000, -8'sd1},  // R3 cross zero
        {5'b11100, -8'sd1},  // R5 read negative
        {5'b01000, -8'sd2},
        {5'b01000, -8'sd3},
        {5'b01001, -8'sd3},  // R7 refused
        {5'b00000, -8'sd3},  // R7 flag drops
        {5'b10000, -8'sd2},  // R3 inc drains negative
        {5'b11100, -8'sd2},  // R5 back to back
        {5'b11100, -8'sd2}
    };

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int sv(logic [VW-1:0] v);
        return int'($signed(v));
    endfunction

    task automatic step(logic u, logic d);
        up_i = u;
        down_i = d;
        @(posedge clk);
        @(negedge clk);
        up_i = 1'b0;
        down_i = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R8 value in reset", sv(value_o), 0);
        chk("R8 rd_valid in reset", int'(rd_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8 value after reset", sv(value_o), 0);
        chk("R8 flags after reset", int'({ovf_o, udf_o}), 0);

        for (int i = 0; i < NV; i++) begin
            logic [12:0] v;
            v = VEC[i];
            step(v[12], v[11]);
            chk("R1/R2 value", sv(value_o), int'($signed(v[7:0])));
            chk("R5 rd_valid", int'(rd_valid_o), int'(v[10]));
            if (v[10]) chk("R5 rd_value", sv(rd_value_o), int'($signed(v[7:0])));
            chk("R6 ovf", int'(ovf_o), int'(v[9]));
            chk("R7 udf", int'(udf_o), int'(v[8]));
        end

        // R5 strobe lasts one cycle only
        step(1'b0, 1'b0);
        chk("R5 strobe one cycle", int'(rd_valid_o), 0);
        chk("R5 rd_value held", sv(rd_value_o), -2);

        // R3 walk from -2 up through zero to +2
        for (int k = -1; k <= 2; k++) begin
            step(1'b1, 1'b0);
            chk("R3 upward crossing", sv(value_o), k);
        end

        // R8 reset at a non-zero value
        rst_n = 1'b0;
        @(negedge clk);
        chk("R8 reset clears value", sv(value_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 read at zero
        step(1'b1, 1'b1);
        chk("R5 read zero valid", int'(rd_valid_o), 1);
        chk("R5 read zero value", sv(rd_value_o), 0);
        chk("R4 read zero hold", sv(value_o), 0);

        // R2 straight to the negative limit, then R6/R7 cleanliness
        for (int k = 1; k <= DEPTH; k++) begin
            step(1'b0, 1'b1);
            chk("R2 descend", sv(value_o), -k);
        end
        chk("R6 no ovf at negative limit", int'(ovf_o), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule